// File: doc/BRIEF.md
# Ones'-Complement Adder/Subtractor with End-Around Carry

This block adds or subtracts two unsigned operands of a parameterized width. A single mode bit chooses the operation. For subtraction the second operand is inverted bit by bit and added to the first. When that addition carries out, the carry is fed back into the least significant position, which gives the positive difference. When it does not carry out, the difference is negative, and the block inverts the raw sum to recover the true magnitude.

The result is always presented as a magnitude and a separate sign flag, never as a two's complement word. Equal operands give the ones'-complement negative-zero pattern internally; the block reports this as a positive zero.

In add mode, the carry out of the top bit is reported on its own output. A parameter selects whether the outputs are taken straight from the combinational path or held in an output register that has a synchronous active-high reset.

Top module: `oc_addsub_eac`

## Requirements
- R1: With `sub_mode` = 0 (add), `magnitude` equals (`op_a` + `op_b`) modulo 2^WIDTH, `carry_out` equals bit WIDTH of that sum, and `negative` is 0.
- R2: With `sub_mode` = 1 (subtract) and `op_a` > `op_b`, `magnitude` equals `op_a` − `op_b` and `negative` is 0.
- R3: With `sub_mode` = 1 and `op_a` < `op_b`, `magnitude` equals `op_b` − `op_a` and `negative` is 1.
- R4: With `sub_mode` = 1 and `op_a` = `op_b`, `magnitude` is 0 and `negative` is 0; a set `negative` never accompanies a zero magnitude.
- R5: `carry_out` is 0 whenever `sub_mode` = 1.
- R6: With REGISTER_OUT = 1, the outputs show the result of the inputs sampled at a rising edge of `clk`, from that edge until the next one. At an edge where `rst` is 1, all three outputs are cleared to 0.
- R7: With REGISTER_OUT = 0, the outputs follow the inputs combinationally, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | WIDTH | First operand (minuend when subtracting) |
| op_b | input | WIDTH | Second operand (subtrahend when subtracting) |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| magnitude | output | WIDTH | Sum, or the absolute value of the difference |
| negative | output | 1 | 1 when the difference is below zero |
| carry_out | output | 1 | Carry out of the addition; 0 when subtracting |

## Verification
Several properties are checked on every cycle:
- the sign flag is raised only when subtracting;
- the carry output stays low when subtracting;
- equal operands give an unsigned zero;
- a raised sign never comes with a zero magnitude;
- the registered sum matches the operands of the previous edge;
- the sign is raised exactly when the previous subtrahend was larger;
- the feedback increment never wraps around.

Only the bench scenarios can show some other behaviours:
- the exact magnitudes across every operand pair in both modes;
- reset clearing of the register;
- the one-cycle latency of the registered build against the zero latency of the combinational build.

// File: rtl/oc_addsub_pkg.sv
package oc_addsub_pkg;

   typedef enum logic {
      OC_ADD = 1'b0,
      OC_SUB = 1'b1
   } oc_op_e;

   localparam int OC_MIN_WIDTH = 1;
   localparam int OC_MAX_WIDTH = 64;

endpackage

// File: rtl/oc_operand_cond.sv
module oc_operand_cond #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] op_b,
   input  logic             sub_mode,
   output logic [WIDTH-1:0] b_out
);
   import oc_addsub_pkg::*;

   oc_op_e op;
   assign op = oc_op_e'(sub_mode);

   // each bit passes through an XOR with the mode: inverted when subtracting
   for (genvar i = 0; i < WIDTH; i++) begin : g_inv
      assign b_out[i] = op_b[i] ^ (op == OC_SUB);
   end

endmodule

// File: rtl/oc_ripple_add.sv
module oc_ripple_add #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   logic [WIDTH:0] carry;

   assign carry[0] = cin;

   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      logic prop;
      assign prop         = a[i] ^ b[i];
      assign sum[i]       = prop ^ carry[i];
      assign carry[i+1]   = (a[i] & b[i]) | (prop & carry[i]);
   end

   assign cout = carry[WIDTH];

endmodule

// File: rtl/oc_result_fix.sv
module oc_result_fix #(
   parameter int WIDTH = 4
) (
   input  logic             sub_mode,
   input  logic [WIDTH-1:0] raw_sum,
   input  logic             raw_cout,
   output logic [WIDTH-1:0] magnitude,
   output logic             negative,
   output logic             carry_out
);
   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ZERO_W   = '0;

   logic             eac_apply;
   logic [WIDTH-1:0] inc_sum;
   logic             inc_cout;
   logic             neg_zero;
   logic             below;

   // feedback carry only when subtracting and the main adder carried out
   assign eac_apply = sub_mode & raw_cout;

   oc_ripple_add #(.WIDTH(WIDTH)) u_inc (
      .a    (raw_sum),
      .b    (ZERO_W),
      .cin  (eac_apply),
      .sum  (inc_sum),
      .cout (inc_cout)
   );

   assign neg_zero = sub_mode & ~raw_cout & (raw_sum == ALL_ONES);
   assign below    = sub_mode & ~raw_cout & ~neg_zero;

   always_comb begin
      if (below) begin
         magnitude = ~raw_sum;
      end else if (neg_zero) begin
         magnitude = ZERO_W;
      end else begin
         magnitude = inc_sum;
      end
      negative  = below;
      carry_out = raw_cout & ~sub_mode;
   end

   always_comb begin
      if (eac_apply) begin
         AST_EAC_NO_WRAP: assert (inc_cout == 1'b0)                // R2
            else $error("end-around increment wrapped");
      end
   end

endmodule

// File: rtl/oc_addsub_eac.sv
module oc_addsub_eac #(
   parameter int WIDTH        = 4,
   parameter bit REGISTER_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             sub_mode,
   output logic [WIDTH-1:0] magnitude,
   output logic             negative,
   output logic             carry_out
);
   import oc_addsub_pkg::*;

   localparam int SUM_W = WIDTH + 1;

   if (WIDTH < OC_MIN_WIDTH || WIDTH > OC_MAX_WIDTH) begin : g_bad_width
      $error("oc_addsub_eac: WIDTH out of range");
   end

   logic [WIDTH-1:0] b_cond;
   logic [WIDTH-1:0] raw_sum;
   logic             raw_cout;
   logic [WIDTH-1:0] mag_c;
   logic             neg_c;
   logic             cy_c;

   oc_operand_cond #(.WIDTH(WIDTH)) u_cond (
      .op_b     (op_b),
      .sub_mode (sub_mode),
      .b_out    (b_cond)
   );

   oc_ripple_add #(.WIDTH(WIDTH)) u_main (
      .a    (op_a),
      .b    (b_cond),
      .cin  (1'b0),
      .sum  (raw_sum),
      .cout (raw_cout)
   );

   oc_result_fix #(.WIDTH(WIDTH)) u_fix (
      .sub_mode  (sub_mode),
      .raw_sum   (raw_sum),
      .raw_cout  (raw_cout),
      .magnitude (mag_c),
      .negative  (neg_c),
      .carry_out (cy_c)
   );

   if (REGISTER_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            magnitude <= '0;
            negative  <= 1'b0;
            carry_out <= 1'b0;
         end else begin
            magnitude <= mag_c;
            negative  <= neg_c;
            carry_out <= cy_c;
         end
      end

      AST_REG_SUM: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && !$past(sub_mode)) |->
            ({carry_out, magnitude} == (SUM_W'($past(op_a)) + SUM_W'($past(op_b)))))
         else $error("registered sum mismatch");                    // R1
      AST_REG_SIGN: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && $past(sub_mode)) |->
            (negative == ($past(op_b) > $past(op_a))))
         else $error("registered sign mismatch");                   // R3
   end else begin : g_comb
      assign magnitude = mag_c;
      assign negative  = neg_c;
      assign carry_out = cy_c;
   end

   AST_NEG_ONLY_SUB: assert property (@(posedge clk) disable iff (rst)
      neg_c |-> sub_mode) else $error("sign in add mode");          // R1
   AST_NO_CARRY_SUB: assert property (@(posedge clk) disable iff (rst)
      sub_mode |-> !cy_c) else $error("carry in subtract mode");    // R5
   AST_EQUAL_ZERO: assert property (@(posedge clk) disable iff (rst)
      (sub_mode && op_a == op_b) |-> (mag_c == '0 && !neg_c))
      else $error("negative zero leaked");                          // R4
   AST_NEG_NONZERO: assert property (@(posedge clk) disable iff (rst)
      neg_c |-> (mag_c != '0)) else $error("signed zero");          // R4
   AST_POS_DIFF: assert property (@(posedge clk) disable iff (rst)
      (sub_mode && op_a > op_b) |-> (!neg_c && mag_c == op_a - op_b))
      else $error("positive difference wrong");                     // R2

endmodule

// File: tb/test_oc_addsub_eac.sv
module test_oc_addsub_eac;

   localparam int W = 4;
   localparam int N = 1 << W;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic         sub_mode = 1'b0;
   logic [W-1:0] mag_r, mag_c;
   logic         neg_r, neg_c, cy_r, cy_c;

   int errors = 0;
   int checks = 0;
   bit done   = 0;

   always #10 clk = ~clk;   // 50 MHz

   oc_addsub_eac #(.WIDTH(W), .REGISTER_OUT(1'b1)) i_oc_addsub_eac (
      .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .sub_mode(sub_mode),
      .magnitude(mag_r), .negative(neg_r), .carry_out(cy_r));

   oc_addsub_eac #(.WIDTH(W), .REGISTER_OUT(1'b0)) i_oc_addsub_eac_comb (
      .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .sub_mode(sub_mode),
      .magnitude(mag_c), .negative(neg_c), .carry_out(cy_c));

   task automatic check(string req, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s a=%0d b=%0d sub=%0b actual=%0d expected=%0d",
                  req, what, op_a, op_b, sub_mode, act, exp);
      end
   endtask

   // behavioural reference: integer arithmetic only
   task automatic compare(string tag, logic [W-1:0] m, logic n, logic c);
      int a = int'(op_a);
      int b = int'(op_b);
      int em, en, ec;
      string req;
      if (!sub_mode) begin
         em = (a + b) % N; en = 0; ec = (a + b) / N; req = "R1";
      end else if (a > b) begin
         em = a - b; en = 0; ec = 0; req = "R2";
      end else if (a < b) begin
         em = b - a; en = 1; ec = 0; req = "R3";
      end else begin
         em = 0; en = 0; ec = 0; req = "R4";
      end
      check({req, "/", tag}, int'(m), em, "magnitude");
      check({req, "/", tag}, int'(n), en, "negative");
      check(sub_mode ? {"R5/", tag} : {req, "/", tag}, int'(c), ec, "carry_out");
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R6: reset clears registered outputs while inputs request a nonzero result
      op_a = 4'd9; op_b = 4'd3; sub_mode = 1'b0;
      repeat (3) @(negedge clk);
      check("R6", int'(mag_r), 0, "reset magnitude");
      check("R6", int'(neg_r), 0, "reset negative");
      check("R6", int'(cy_r), 0, "reset carry_out");
      rst = 1'b0;

      // exhaustive sweep: inputs change after a falling edge, are sampled at
      // the next rising edge, and are checked at the following falling edge
      for (int m = 0; m < 2; m++) begin
         for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
               op_a = W'(a); op_b = W'(b); sub_mode = m[0];
               #1;
               compare("R7", mag_c, neg_c, cy_c);   // R7: no clock delay
               @(negedge clk);
               compare("R6", mag_r, neg_r, cy_r);   // R6: one edge of latency
            end
         end
      end

      // R6: latency seen directly: new inputs are not yet visible before the edge
      op_a = 4'd2; op_b = 4'd7; sub_mode = 1'b1;
      @(negedge clk);
      op_a = 4'd15; op_b = 4'd15; sub_mode = 1'b0;
      #1;
      check("R6", int'(mag_r), 5, "held magnitude");
      check("R6", int'(neg_r), 1, "held negative");
      @(negedge clk);
      check("R6", int'(mag_r), 14, "next magnitude");
      check("R6", int'(cy_r), 1, "next carry_out");

      // R6: mid-run synchronous reset clears a negative result
      op_a = 4'd1; op_b = 4'd8; sub_mode = 1'b1;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check("R6", int'(mag_r), 0, "mid reset magnitude");
      check("R6", int'(neg_r), 0, "mid reset negative");
      rst = 1'b0;
      @(negedge clk);
      check("R3", int'(mag_r), 7, "after reset magnitude");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule